// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block takes every reset request of a small system and turns them into three separate reset outputs: one for the processor core, one for the on-chip peripherals and one for the debug port. The requests are a digital power-on indication, an active-low external reset pin, a software request that resets only the peripherals, power-on and system requests from the watchdog and from the hibernation logic, a hardware system-service request and a main-oscillator failure request. Each source reaches only the outputs in its own scope. Power-on is the only source that reaches the debug port.

Every request other than power-on first passes through a two-flop synchroniser. Power-on asserts all outputs asynchronously. Each output is released on a clock edge and stays asserted for at least eight cycles. While the external pin is held low, the core and peripherals stay in reset. This holds even after power-on has gone away, so initialisation cannot begin.

A 32-bit reset-cause register records which sources have fired. Its bits are sticky: later resets do not clear them. Software clears a bit by writing zero to it. Power-on leaves only its own bit set.

Top module: `rstc_top`

## Requirements
- R1: The software peripheral request asserts the peripheral reset and never the core reset.
- R2: The external pin, both watchdog requests, both hibernation requests, the system-service request and the oscillator-failure request each assert both the core and the peripheral reset.
- R3: A request held high before rising edge 1 first shows on its reset output after rising edge 3. Two of those edges are spent in the synchroniser and one in the output register.
- R4: The debug reset is asserted only by power-on and stays low for every other source.
- R5: Cause bit positions are: 0 power-on, 1 external pin, 2 software peripheral, 3 watchdog power-on, 4 watchdog system, 5 hibernation power-on, 6 hibernation system, 7 system service, 8 oscillator failure. A synchronised active request sets its bit. Bits 31:9 read as zero.
- R6: Cause bits stay set through later non-power-on resets until software clears them.
- R7: A write clears each cause bit whose data bit is 0 and leaves each bit whose data bit is 1. A request arriving in the same cycle as a clearing write wins.
- R8: While the external pin is low, the core and peripheral resets stay asserted, even after power-on has been released.
- R9: Once a reset output asserts, it stays asserted for at least 8 cycles. After its synchronised request drops, it stays asserted for 7 more rising edges.
- R10: Power-on asserts all three outputs at once and makes the cause register read exactly 1. After power-on falls, the outputs release at the 8th rising edge.
- R11: Requests synchronised in the same cycle set all of their cause bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_per_req | input | 1 | Software peripheral reset request |
| wdt_por_req | input | 1 | Watchdog power-on reset request |
| wdt_sys_req | input | 1 | Watchdog system reset request |
| hib_por_req | input | 1 | Hibernation power-on reset request |
| hib_sys_req | input | 1 | Hibernation system reset request |
| svc_req | input | 1 | Hardware system-service reset request |
| osc_fail_req | input | 1 | Main-oscillator failure reset request |
| cause_wr | input | 1 | Write strobe for the cause register |
| cause_wdata | input | 32 | Write data; 0 bits clear cause bits |
| cause_rdata | output | 32 | Cause register contents |
| core_rst_o | output | 1 | Core reset, active high |
| per_rst_o | output | 1 | Peripheral reset, active high |
| dbg_rst_o | output | 1 | Debug-port reset, active high |

## Verification
The bench checks that a one-cycle software pulse yields exactly eight cycles of peripheral reset with the core untouched. A design that mixed up the source scopes would assert the core here, and one that miscounted the stretch would give seven or nine cycles. It holds the external pin low across power-on release, where a design that let power-on dominate would drop its outputs after eight cycles. It also issues a clearing write while a request is active, so a design where the write wins loses the new cause bit. Two requests in the same cycle catch a cause register that keeps only one of them.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int CAUSE_W = 32;
    localparam int NUM_SRC = 9;
    localparam int NUM_DOM = 3;

    // Source index doubles as the cause bit position.
    typedef enum int unsigned {
        SRC_POR = 0,
        SRC_EXT = 1,
        SRC_SWP = 2,
        SRC_WDP = 3,
        SRC_WDS = 4,
        SRC_HBP = 5,
        SRC_HBS = 6,
        SRC_SVC = 7,
        SRC_OSC = 8
    } src_e;

    typedef enum int unsigned {
        DOM_CORE = 0,
        DOM_PER  = 1,
        DOM_DBG  = 2
    } dom_e;

    typedef struct packed {
        logic dbg;
        logic per;
        logic core;
    } scope_t;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    function automatic scope_t src_scope(input int unsigned src);
        scope_t s;
        case (src)
            SRC_POR: s = '{dbg: 1'b1, per: 1'b1, core: 1'b1};
            SRC_SWP: s = '{dbg: 1'b0, per: 1'b1, core: 1'b0};
            default: s = '{dbg: 1'b0, per: 1'b1, core: 1'b1};
        endcase
        return s;
    endfunction

    function automatic src_vec_t dom_sources(input int unsigned dom);
        src_vec_t m;
        logic [NUM_DOM-1:0] sc;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            sc = src_scope(i);
            m[i] = sc[dom];
        end
        return m;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int MIN_PULSE = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic req_i,
    output logic rst_o
);

    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MIN_PULSE - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             rst_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= RELOAD;
            rst_q <= 1'b1;
        end else if (req_i) begin
            cnt_q <= RELOAD;
            rst_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            rst_q <= 1'b1;
        end else begin
            rst_q <= 1'b0;
        end
    end

    assign rst_o = rst_q;

    // Width monitor: high-cycle run length, saturating at MIN_PULSE.
    localparam int RUN_W = CNT_W + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            run_q <= RUN_W'(MIN_PULSE);
        end else if (rst_o) begin
            if (run_q < RUN_W'(MIN_PULSE)) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R8
    req_holds_chk: assert property (@(posedge clk) disable iff (arst)
        req_i |=> rst_o);

    // R9
    min_width_chk: assert property (@(posedge clk) disable iff (arst)
        $fell(rst_o) |-> (run_q >= RUN_W'(MIN_PULSE)));

endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
(
    input  logic               clk,
    input  logic               arst,
    input  src_vec_t           set_i,
    input  logic               wr_en,
    input  logic [CAUSE_W-1:0] wdata,
    output logic [CAUSE_W-1:0] rdata
);

    localparam src_vec_t POR_ONLY = src_vec_t'(1) << SRC_POR;

    src_vec_t cause_q;
    src_vec_t keep_mask;

    always_comb begin
        keep_mask = wr_en ? wdata[NUM_SRC-1:0] : '1;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cause_q <= POR_ONLY;
        end else begin
            cause_q <= (cause_q & keep_mask) | set_i;
        end
    end

    assign rdata = {{(CAUSE_W-NUM_SRC){1'b0}}, cause_q};

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (arst)
        !wr_en |=> (($past(cause_q) & ~cause_q) == '0));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (arst)
        (wr_en && set_i == '0) |=> (cause_q == ($past(cause_q) & $past(wdata[NUM_SRC-1:0]))));

    // R11
    or_chk: assert property (@(posedge clk) disable iff (arst)
        1'b1 |=> ((cause_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int MIN_PULSE   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               ext_rst_n,
    input  logic               sw_per_req,
    input  logic               wdt_por_req,
    input  logic               wdt_sys_req,
    input  logic               hib_por_req,
    input  logic               hib_sys_req,
    input  logic               svc_req,
    input  logic               osc_fail_req,
    input  logic               cause_wr,
    input  logic [CAUSE_W-1:0] cause_wdata,
    output logic [CAUSE_W-1:0] cause_rdata,
    output logic               core_rst_o,
    output logic               per_rst_o,
    output logic               dbg_rst_o
);

    src_vec_t           raw_req;
    src_vec_t           sync_req;
    logic [NUM_DOM-1:0] dom_req;
    logic [NUM_DOM-1:0] dom_rst;

    always_comb begin
        raw_req          = '0;
        raw_req[SRC_EXT] = ~ext_rst_n;
        raw_req[SRC_SWP] = sw_per_req;
        raw_req[SRC_WDP] = wdt_por_req;
        raw_req[SRC_WDS] = wdt_sys_req;
        raw_req[SRC_HBP] = hib_por_req;
        raw_req[SRC_HBS] = hib_sys_req;
        raw_req[SRC_SVC] = svc_req;
        raw_req[SRC_OSC] = osc_fail_req;
    end

    rstc_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .arst (por_i),
        .d_i  (raw_req),
        .q_o  (sync_req)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        localparam src_vec_t MASK = dom_sources(d);

        assign dom_req[d] = |(sync_req & MASK);

        rstc_stretch #(
            .MIN_PULSE (MIN_PULSE)
        ) u_stretch (
            .clk   (clk),
            .arst  (por_i),
            .req_i (dom_req[d]),
            .rst_o (dom_rst[d])
        );
    end

    rstc_cause u_cause (
        .clk   (clk),
        .arst  (por_i),
        .set_i (sync_req),
        .wr_en (cause_wr),
        .wdata (cause_wdata),
        .rdata (cause_rdata)
    );

    assign core_rst_o = dom_rst[DOM_CORE];
    assign per_rst_o  = dom_rst[DOM_PER];
    assign dbg_rst_o  = dom_rst[DOM_DBG];

    // R4
    dbg_por_only_chk: assert property (@(posedge clk) disable iff (por_i)
        !dbg_rst_o |=> !dbg_rst_o);

    // R1
    core_rise_src_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(core_rst_o) |-> $past(dom_req[DOM_CORE]));

endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;

    localparam int MINP = 8;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic [8:0]  req_v = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        core_rst, per_rst, dbg_rst;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rstc_top dut (
        .clk          (clk),
        .por_i        (por),
        .ext_rst_n    (~req_v[1]),
        .sw_per_req   (req_v[2]),
        .wdt_por_req  (req_v[3]),
        .wdt_sys_req  (req_v[4]),
        .hib_por_req  (req_v[5]),
        .hib_sys_req  (req_v[6]),
        .svc_req      (req_v[7]),
        .osc_fail_req (req_v[8]),
        .cause_wr     (wr),
        .cause_wdata  (wdata),
        .cause_rdata  (rdata),
        .core_rst_o   (core_rst),
        .per_rst_o    (per_rst),
        .dbg_rst_o    (dbg_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int          mcnt [3];
    bit          mout [3];
    bit [8:0]    h1, h2;
    bit [31:0]   mcause;
    bit [2:0]    dreq;

    function automatic bit [2:0] scope_of(input int i);
        // bit0 core, bit1 periph, bit2 debug
        if (i == 2) return 3'b010;
        return 3'b011;
    endfunction

    always @(posedge clk or posedge por) begin
        if (por) begin
            h1 = '0;
            h2 = '0;
            for (int d = 0; d < 3; d++) begin
                mcnt[d] = MINP - 1;
                mout[d] = 1'b1;
            end
            mcause = 32'h1;
        end else begin
            dreq = '0;
            for (int i = 1; i < 9; i++) if (h2[i]) dreq |= scope_of(i);
            for (int d = 0; d < 3; d++) begin
                if (dreq[d]) begin
                    mcnt[d] = MINP - 1;
                    mout[d] = 1'b1;
                end else if (mcnt[d] > 0) begin
                    mcnt[d]--;
                    mout[d] = 1'b1;
                end else begin
                    mout[d] = 1'b0;
                end
            end
            if (wr) mcause = mcause & wdata;
            mcause = mcause | {23'b0, h2};
            h2 = h1;
            h1 = req_v;
            h1[0] = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 core vs model", {31'b0, core_rst}, {31'b0, mout[0]});
            chk("R1 periph vs model", {31'b0, per_rst}, {31'b0, mout[1]});
            chk("R4 debug vs model", {31'b0, dbg_rst}, {31'b0, mout[2]});
            chk("R5 cause vs model", rdata, mcause);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            finish_run();
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse the given sources for one cycle and watch the outputs for 14 cycles.
    task automatic pulse_watch(input logic [8:0] bits, output bit saw_core,
                               output bit saw_per, output bit saw_dbg);
        saw_core = 0; saw_per = 0; saw_dbg = 0;
        @(negedge clk); #2 req_v = bits;
        @(negedge clk); #2 req_v = '0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            saw_core |= core_rst;
            saw_per  |= per_rst;
            saw_dbg  |= dbg_rst;
        end
    endtask

    task automatic cause_write(input logic [31:0] v);
        @(negedge clk); #2 wr = 1'b1; wdata = v;
        @(negedge clk); #2 wr = 1'b0; wdata = '0;
    endtask

    initial begin
        bit sc, sp, sd;
        int run;
        bit core_seen;

        // R10: power-on state
        step(2);
        chk("R10 core during por", {31'b0, core_rst}, 32'h1);
        chk("R10 periph during por", {31'b0, per_rst}, 32'h1);
        chk("R10 debug during por", {31'b0, dbg_rst}, 32'h1);
        chk("R10 cause during por", rdata, 32'h1);

        #2 por = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            chk("R10 release timing", {29'b0, dbg_rst, per_rst, core_rst},
                (i < 8) ? 32'h7 : 32'h0);
        end
        step(3);

        // R3, R1, R9: one-cycle software peripheral request
        @(negedge clk); #2 req_v[2] = 1'b1;
        @(negedge clk);
        chk("R3 latency edge1", {31'b0, per_rst}, 32'h0);
        #2 req_v[2] = 1'b0;
        @(negedge clk);
        chk("R3 latency edge2", {31'b0, per_rst}, 32'h0);
        @(negedge clk);
        chk("R3 latency edge3", {31'b0, per_rst}, 32'h1);
        run = 0;
        core_seen = 0;
        while (per_rst && run < 20) begin
            run++;
            core_seen |= core_rst;
            @(negedge clk);
        end
        chk("R9 periph width", run, MINP);
        chk("R1 core untouched", {31'b0, core_seen}, 32'h0);
        chk("R5 software cause bit", rdata, 32'h5);

        // R2, R4: each core-scoped source alone
        for (int s = 1; s < 9; s++) begin
            if (s != 2) begin
                pulse_watch(9'(1) << s, sc, sp, sd);
                chk("R2 core asserted", {31'b0, sc}, 32'h1);
                chk("R2 periph asserted", {31'b0, sp}, 32'h1);
                chk("R4 debug untouched", {31'b0, sd}, 32'h0);
            end
        end
        // R6: earlier bits kept through the later resets
        chk("R6 sticky causes", rdata, 32'h1FF);

        // R7: write-zero clears, write-one keeps
        cause_write(~32'h4);
        @(negedge clk);
        chk("R7 clear one bit", rdata, 32'h1FB);
        cause_write(32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 write ones keep", rdata, 32'h1FB);
        cause_write(32'h0);
        @(negedge clk);
        chk("R7 clear all", rdata, 32'h0);

        // R11: two sources in the same cycle
        pulse_watch(9'h110, sc, sp, sd);
        chk("R11 both causes", rdata, 32'h110);
        cause_write(32'h0);

        // R7: active request wins over a clearing write
        @(negedge clk); #2 req_v[5] = 1'b1;
        step(4);
        cause_write(32'h0);
        @(negedge clk);
        chk("R7 set wins over clear", rdata, 32'h20);
        #2 req_v[5] = 1'b0;
        step(12);

        // R8, R10: pin held low across power-on release
        @(negedge clk); #2 por = 1'b1; req_v[1] = 1'b1;
        @(negedge clk);
        chk("R10 cause after power-on", rdata, 32'h1);
        step(2);
        #2 por = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R8 core held by pin", {31'b0, core_rst}, 32'h1);
            chk("R8 periph held by pin", {31'b0, per_rst}, 32'h1);
        end
        chk("R4 debug released", {31'b0, dbg_rst}, 32'h0);
        chk("R5 pin cause", rdata, 32'h3);
        #2 req_v[1] = 1'b0;
        step(12);
        chk("R8 release after pin", {30'b0, per_rst, core_rst}, 32'h0);

        step(2);
        finish_run();
    end

endmodule